// File: doc/BRIEF.md
# Random Dummy-Operation Scheduler

This block is a sequencer that sits in front of an iterative cipher datapath and randomises when the protected operation happens. When a start request arrives it draws a pseudo-random count N from an internal 16-bit linear feedback shift register and issues N dummy operations before the one real operation. Each dummy operation drives the datapath enable with filler data taken from the same register. Dummy cycles therefore switch the datapath much as a real cycle does, but they carry no work tied to the secret computation.

The real operand is captured when the start is accepted. It is issued to the datapath exactly once, on a cycle chosen uniformly from a window of 2^WIN_W positions. A one-cycle done pulse follows. Each dummy cycle adds one cycle of latency, so throughput is traded for resistance to timing-aligned power analysis. The dummy/real flag is meant for logic inside the chip that must discard dummy results. It must never leave the protected boundary.

Top module: `dummy_sched`

## Requirements
- R1: While reset is asserted the shift register loads `seed_i`. A seed of zero is replaced by 16'hACE1. After reset the block is idle with `dp_en_o`, `dp_dummy_o` and `done_o` low.
- R2: The shift register advances on every clock after reset: next = {q[14:0], q[15]^q[14]^q[12]^q[3]} (taps 16, 15, 13, 4, bit 15 being the oldest).
- R3: A start accepted in a cycle draws N = the low WIN_W bits of the shift register in that cycle. Exactly N consecutive dummy cycles follow, starting on the next cycle, and then one real cycle. Over many starts every value 0..2^WIN_W-1 occurs.
- R4: When N is 0, the real operand is issued on the first cycle after the start.
- R5: On a dummy cycle `dp_en_o`=1 and `dp_dummy_o`=1. `dp_data_o` is the filler of the current shift-register value: 16-bit chunk j (from the LSB) equals q XOR (j*16'h9E37 mod 2^16), cut to DATA_W bits.
- R6: On the single real cycle `dp_en_o`=1, `dp_dummy_o`=0 and `dp_data_o` equals the operand sampled with the start. Later changes of `oper_i` have no effect.
- R7: `done_o` is high for exactly one cycle, the cycle after the real issue. The block is idle on the cycle after that.
- R8: A start request that arrives while an operation is in progress (dummy, real or done cycle) is ignored. No further issue follows it.
- R9: Whenever `dp_en_o` is low, `dp_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seed_i | input | 16 | Shift-register seed loaded during reset |
| start_i | input | 1 | Request one protected operation (taken only when idle) |
| oper_i | input | DATA_W | Real operand, sampled with an accepted start |
| dp_en_o | output | 1 | Datapath enable, high on dummy and real cycles |
| dp_data_o | output | DATA_W | Datapath operand: filler on dummy cycles, real operand on the real cycle |
| dp_dummy_o | output | 1 | High on dummy cycles; for internal use only |
| done_o | output | 1 | One-cycle pulse after the real issue |

## Verification
The hardest cases to reach from the ports are the two ends of the window. A draw of zero must put the real issue straight after the start. A draw of the largest value must give the longest run of dummy cycles. Both depend on the shift-register phase at the moment of the start. The bench keeps its own model of the register from the seed and holds back the start until the model shows the wanted low bits, then it starts. The many random starts in between, some with extra start pulses during busy cycles, cover the rest of the window and check that every value appears.

// File: rtl/dummy_sched_pkg.sv
package dummy_sched_pkg;

    localparam int unsigned LFSR_W = 16;
    localparam logic [LFSR_W-1:0] SEED_FALLBACK = 16'hACE1;
    localparam logic [LFSR_W-1:0] FILL_SPREAD   = 16'h9E37;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DUMMY = 2'd1,
        ST_REAL  = 2'd2,
        ST_DONE  = 2'd3
    } sched_state_e;

    // One step of the maximal-length register, taps 16,15,13,4.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

endpackage

// File: rtl/ds_lfsr.sv
module ds_lfsr
    import dummy_sched_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LFSR_W-1:0] seed_i,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] lfsr_d, lfsr_q;
    logic [LFSR_W-1:0] seed_safe;

    always_comb begin
        seed_safe = (seed_i == '0) ? SEED_FALLBACK : seed_i;
        lfsr_d    = lfsr_step(lfsr_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lfsr_q <= seed_safe;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign state_o = lfsr_q;

endmodule

// File: rtl/ds_filler.sv
module ds_filler
    import dummy_sched_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [LFSR_W-1:0] lfsr_i,
    output logic [DATA_W-1:0] fill_o
);

    localparam int unsigned NCHUNK = (DATA_W + LFSR_W - 1) / LFSR_W;
    localparam int unsigned WIDE_W = NCHUNK * LFSR_W;

    logic [WIDE_W-1:0] wide;

    for (genvar j = 0; j < NCHUNK; j++) begin : g_chunk
        localparam logic [LFSR_W-1:0] MASK = LFSR_W'(j * 32'(FILL_SPREAD));
        assign wide[j*LFSR_W +: LFSR_W] = lfsr_i ^ MASK;
    end

    assign fill_o = wide[DATA_W-1:0];

endmodule

// File: rtl/ds_fsm.sv
module ds_fsm
    import dummy_sched_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WIN_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [WIN_W-1:0]  draw_i,
    input  logic [DATA_W-1:0] oper_i,
    output sched_state_e      state_o,
    output logic [DATA_W-1:0] oper_o
);

    localparam logic [WIN_W-1:0] LAST_DUMMY = WIN_W'(1);

    typedef struct packed {
        sched_state_e      state;
        logic [WIN_W-1:0]  left;
        logic [DATA_W-1:0] oper;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.oper  = oper_i;
                    ctrl_d.left  = draw_i;
                    ctrl_d.state = (draw_i == '0) ? ST_REAL : ST_DUMMY;
                end
            end
            ST_DUMMY: begin
                if (ctrl_q.left == LAST_DUMMY) begin
                    ctrl_d.state = ST_REAL;
                end
                ctrl_d.left = ctrl_q.left - LAST_DUMMY;
            end
            ST_REAL: begin
                ctrl_d.state = ST_DONE;
            end
            ST_DONE: begin
                ctrl_d.state = ST_IDLE;
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '{state: ST_IDLE, left: '0, oper: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state_o = ctrl_q.state;
    assign oper_o  = ctrl_q.oper;

endmodule

// File: rtl/dummy_sched.sv
module dummy_sched
    import dummy_sched_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WIN_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [15:0]       seed_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] oper_i,
    output logic              dp_en_o,
    output logic [DATA_W-1:0] dp_data_o,
    output logic              dp_dummy_o,
    output logic              done_o
);

    logic [LFSR_W-1:0] lfsr_q;
    logic [DATA_W-1:0] fill;
    logic [DATA_W-1:0] oper_q;
    sched_state_e      state;

    ds_lfsr i_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .seed_i  (seed_i),
        .state_o (lfsr_q)
    );

    ds_filler #(.DATA_W(DATA_W)) i_filler (
        .lfsr_i (lfsr_q),
        .fill_o (fill)
    );

    ds_fsm #(.DATA_W(DATA_W), .WIN_W(WIN_W)) i_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .draw_i  (lfsr_q[WIN_W-1:0]),
        .oper_i  (oper_i),
        .state_o (state),
        .oper_o  (oper_q)
    );

    always_comb begin
        dp_en_o    = 1'b0;
        dp_dummy_o = 1'b0;
        done_o     = 1'b0;
        dp_data_o  = '0;
        unique case (state)
            ST_DUMMY: begin
                dp_en_o    = 1'b1;
                dp_dummy_o = 1'b1;
                dp_data_o  = fill;
            end
            ST_REAL: begin
                dp_en_o   = 1'b1;
                dp_data_o = oper_q;
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                dp_en_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dummy_sched_chk.sv
module dummy_sched_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WIN_W  = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              dp_en_o,
    input logic [DATA_W-1:0] dp_data_o,
    input logic              dp_dummy_o,
    input logic              done_o,
    input logic [15:0]       lfsr_q
);

    localparam int unsigned MAX_N = (1 << WIN_W) - 1;

    logic [WIN_W:0] run_q;
    logic           real_cyc;

    assign real_cyc = dp_en_o && !dp_dummy_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (done_o) begin
            run_q <= '0;
        end else if (dp_en_o && dp_dummy_o) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R2: the register never reaches the all-zero lock-up state
    a_r2_lfsr_alive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_q != 16'h0);

    // R3: dummy cycles of one operation stay inside the window
    a_r3_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= (WIN_W+1)'(MAX_N));

    // R5: the dummy flag only appears with the enable
    a_r5_dummy_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dp_dummy_o |-> dp_en_o);

    // R6: the real issue lasts one cycle
    a_r6_single_real: assert property (@(posedge clk_i) disable iff (!rst_ni)
        real_cyc |=> !real_cyc);

    // R7: done follows the real issue and lasts one cycle
    a_r7_done_after_real: assert property (@(posedge clk_i) disable iff (!rst_ni)
        real_cyc |=> done_o);
    a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o && !dp_en_o);

    // R9: bus is quiet without the enable
    a_r9_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dp_en_o |-> dp_data_o == '0);

endmodule

bind dummy_sched dummy_sched_chk #(.DATA_W(DATA_W), .WIN_W(WIN_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dp_en_o    (dp_en_o),
    .dp_data_o  (dp_data_o),
    .dp_dummy_o (dp_dummy_o),
    .done_o     (done_o),
    .lfsr_q     (lfsr_q)
);

// File: tb/test_dummy_sched.sv
`timescale 1ns/1ps
module test_dummy_sched;

    localparam int DATA_W = 32;
    localparam int WIN_W  = 3;
    localparam int NWIN   = 1 << WIN_W;
    localparam int NCH    = (DATA_W + 15) / 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       seed = 16'h0;
    logic              start = 1'b0;
    logic [DATA_W-1:0] oper = '0;
    logic              dp_en;
    logic [DATA_W-1:0] dp_data;
    logic              dp_dummy;
    logic              done;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;
    bit [NWIN-1:0] seen = '0;
    logic [15:0] model;

    always #2.5 clk = ~clk;

    dummy_sched #(.DATA_W(DATA_W), .WIN_W(WIN_W)) i_dummy_sched (
        .clk_i(clk), .rst_ni(rst_n), .seed_i(seed), .start_i(start),
        .oper_i(oper), .dp_en_o(dp_en), .dp_data_o(dp_data),
        .dp_dummy_o(dp_dummy), .done_o(done)
    );

    // Register model from R1/R2
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) model <= (seed == 16'h0) ? 16'hACE1 : seed;
        else        model <= {model[14:0], model[15] ^ model[14] ^ model[12] ^ model[3]};
    end

    function automatic logic [DATA_W-1:0] fill_exp(input logic [15:0] q);
        logic [NCH*16-1:0] w;
        for (int j = 0; j < NCH; j++) w[j*16 +: 16] = q ^ 16'(j * 32'h9E37);
        return w[DATA_W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        seed  = s;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dp_en && !dp_dummy && !done, "R1", "idle after reset",
            {dp_en, dp_dummy, done}, 0);
        chk(dp_data == '0, "R9", "bus zero after reset", dp_data, 0);
    endtask

    task automatic wait_draw(input int v);
        int guard = 0;
        while (model[WIN_W-1:0] != WIN_W'(v) && guard < 100) begin
            @(negedge clk);
            guard++;
            chk(!dp_en && dp_data == '0, "R9", "idle bus quiet", dp_data, 0);
        end
    endtask

    task automatic run_op(input bit poke);
        int n_exp;
        int cnt = 0;
        logic [DATA_W-1:0] op_val;
        op_val = DATA_W'({$urandom, $urandom});
        n_exp  = int'(model[WIN_W-1:0]);
        seen[n_exp] = 1'b1;
        oper  = op_val;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        oper  = ~op_val;            // R6: must not matter
        while (dp_en && dp_dummy && cnt <= NWIN) begin
            chk(dp_data == fill_exp(model), "R5 R2", "dummy filler", dp_data, fill_exp(model));
            start = poke && (cnt == 0); // R8: busy start
            cnt++;
            @(negedge clk);
            start = 1'b0;
        end
        chk(cnt == n_exp, "R3", "dummy count", cnt, n_exp);
        if (n_exp == 0) chk(cnt == 0 && dp_en, "R4", "real right after start", cnt, 0);
        chk(dp_en && !dp_dummy, "R6", "real flags", {dp_en, dp_dummy}, 2'b10);
        chk(dp_data == op_val, "R6", "real operand", dp_data, op_val);
        start = poke;               // R8: start during real cycle
        @(negedge clk);
        start = 1'b0;
        chk(done && !dp_en, "R7", "done after real", {done, dp_en}, 2'b10);
        start = poke;               // R8: start during done cycle
        @(negedge clk);
        start = 1'b0;
        chk(!done && !dp_en && dp_data == '0, "R7", "idle after done",
            {done, dp_en}, 0);
        @(negedge clk);
        chk(!dp_en && !done, "R8", "busy start ignored", {dp_en, done}, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: zero seed falls back to the constant (visible through filler checks)
        do_reset(16'h0);
        wait_draw(0);
        run_op(1'b0);               // R4 directed
        wait_draw(NWIN - 1);
        run_op(1'b1);               // longest window, R3
        do_reset(16'h5A3C);
        wait_draw(NWIN - 1);
        run_op(1'b0);
        wait_draw(0);
        run_op(1'b1);
        for (int i = 0; i < 200; i++) begin
            repeat ($urandom_range(0, 3)) @(negedge clk);
            run_op(1'($urandom_range(0, 1)));
        end
        chk(&seen, "R3", "every window value drawn", 64'(seen), {NWIN{1'b1}});
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule